// File: doc/BRIEF.md
# Connection Memory Pattern Fill Engine

This block loads a fixed pattern into two connection memories, so that software does not have to program every word one at a time. The first is a 2048-word backplane memory. The second is a 512-word lower local memory. A third memory, the upper local half, sits beside them and is never written by the fill.

Software first raises the block-program mode input. It then sets the trigger bit with a one-cycle pulse. The engine then sweeps one shared address counter over both memories, writing one word of each memory per clock cycle:

- each backplane word receives the 3-bit backplane pattern at bits 13..11;
- each lower local word receives the 4-bit local pattern at bits 15..12;
- every other bit of a filled word is zero.

The local memory is shorter, so its writes stop once its last address has been written. When the sweep ends, the trigger bit clears itself. If the mode input is dropped part-way through, the fill is abandoned.

While the engine is busy, processor writes to the two filled memories are discarded. Each memory has its own processor write port and an asynchronous read port.

Top module: `cmfill_top`

## Requirements
- R1: After reset, `busy` and `trig_bit` are both 0.
- R2: A fill starts only when `trig_set` is pulsed while `blk_mode` is 1. Pulsing `trig_set` while `blk_mode` is 0 leaves `trig_bit` and `busy` at 0 and writes no memory.
- R3: After a complete fill, every backplane word equals the 3-bit backplane pattern placed at bits 13..11, with all other bits 0.
- R4: After a complete fill, every lower local word equals the 4-bit local pattern placed at bits 15..12, with all other bits 0.
- R5: The upper local memory keeps its contents across a fill.
- R6: `busy` rises on the edge that accepts the trigger and stays high for exactly max(backplane depth, local depth) cycles. `trig_bit` is 1 throughout and clears on the edge where `busy` falls.
- R7: A fill completes within two frames of `FRAME_CYC` clock cycles each.
- R8: Processor writes to the backplane or lower local memory are discarded while `busy` is 1, and take effect while it is 0.
- R9: If `blk_mode` is 0 at a clock edge during a fill, no word is written on that edge, and `busy` and `trig_bit` fall on it. Words not yet reached keep their previous contents.
- R10: The patterns are sampled when the fill starts. Later changes to the pattern inputs do not affect the words being written.
- R11: A `trig_set` pulse during a fill neither restarts nor lengthens it. The fill address steps by one on every busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_mode | input | 1 | Block-program mode enable |
| trig_set | input | 1 | One-cycle pulse that sets the trigger bit |
| bp_pat_in | input | 3 | Backplane fill pattern |
| lo_pat_in | input | 4 | Lower local fill pattern |
| trig_bit | output | 1 | Trigger bit, cleared by hardware at the end of a fill |
| busy | output | 1 | Fill in progress |
| cpu_bp_we | input | 1 | Processor write enable, backplane memory |
| cpu_bp_addr | input | 11 | Processor write address, backplane memory |
| cpu_bp_wdata | input | 16 | Processor write data, backplane memory |
| bp_rd_addr | input | 11 | Read address, backplane memory |
| bp_rd_data | output | 16 | Read data, backplane memory |
| cpu_lo_we | input | 1 | Processor write enable, lower local memory |
| cpu_lo_addr | input | 9 | Processor write address, lower local memory |
| cpu_lo_wdata | input | 16 | Processor write data, lower local memory |
| lo_rd_addr | input | 9 | Read address, lower local memory |
| lo_rd_data | output | 16 | Read data, lower local memory |
| cpu_hi_we | input | 1 | Processor write enable, upper local memory |
| cpu_hi_addr | input | 9 | Processor write address, upper local memory |
| cpu_hi_wdata | input | 16 | Processor write data, upper local memory |
| hi_rd_addr | input | 9 | Read address, upper local memory |
| hi_rd_data | output | 16 | Read data, upper local memory |

## Verification
A processor write and a fill write can compete for the same memory in the same cycle. This is provoked at both ends of a fill:

- A backplane write to address 3 is issued in the very cycle the trigger is accepted. It lands because `busy` is still low, and the fill later overwrites it.
- Writes of all-ones to address 0 of both memories are issued during the last busy cycle. They must be discarded.

The pass criterion is the same in both cases: after the fill, those addresses hold the pattern word and not all-ones. A mid-fill trigger pulse and a mid-fill pattern change are also applied in the same run. They are judged by the measured busy length and by every word read back afterwards.

// File: rtl/cmfill_pkg.sv
package cmfill_pkg;
  localparam int unsigned CM_W       = 16;
  localparam int unsigned BP_PAT_W   = 3;
  localparam int unsigned BP_FLD_LSB = 11;
  localparam int unsigned LO_PAT_W   = 4;
  localparam int unsigned LO_FLD_LSB = 12;

  typedef logic [CM_W-1:0] cm_word_t;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cmfill_field.sv
module cmfill_field #(
  parameter int unsigned W   = 16,
  parameter int unsigned FW  = 3,
  parameter int unsigned LSB = 11
) (
  input  logic [FW-1:0] pat,
  output logic [W-1:0]  word
);
  // Place the pattern at its field; every other bit is tied to zero.
  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    if (i >= int'(LSB) && i < int'(LSB + FW)) begin : g_fld
      assign word[i] = pat[i-int'(LSB)];
    end else begin : g_zero
      assign word[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cmfill_mem.sv
module cmfill_mem #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [W-1:0]  fill_data,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [W-1:0]  cpu_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem_q [DEPTH];

  // Fill writes win; the top keeps both enables apart anyway.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      mem_q[fill_addr] <= fill_data;
    end else if (cpu_we) begin
      mem_q[cpu_addr] <= cpu_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/cmfill_seq.sv
module cmfill_seq
  import cmfill_pkg::*;
#(
  parameter int unsigned BP_DEPTH = 2048,
  parameter int unsigned LO_DEPTH = 512,
  parameter int unsigned NMAX     = (BP_DEPTH > LO_DEPTH) ? BP_DEPTH : LO_DEPTH,
  parameter int unsigned AW       = $clog2(NMAX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_mode,
  input  logic                trig_set,
  input  logic [BP_PAT_W-1:0] bp_pat_in,
  input  logic [LO_PAT_W-1:0] lo_pat_in,
  output logic                busy,
  output logic                trig_bit,
  output logic [AW-1:0]       fill_addr,
  output logic                bp_fill_we,
  output logic                lo_fill_we,
  output logic [BP_PAT_W-1:0] bp_pat,
  output logic [LO_PAT_W-1:0] lo_pat
);
  localparam logic [AW-1:0] LAST   = AW'(NMAX - 1);
  localparam logic [AW:0]   BP_LIM = (AW+1)'(BP_DEPTH);
  localparam logic [AW:0]   LO_LIM = (AW+1)'(LO_DEPTH);

  fill_state_e         state_q, state_d;
  logic [AW-1:0]       addr_q, addr_d;
  logic                trig_q, trig_d;
  logic [BP_PAT_W-1:0] bpp_q, bpp_d;
  logic [LO_PAT_W-1:0] lop_q, lop_d;
  logic                start, step_en;

  assign start   = (state_q == FS_IDLE) && blk_mode && trig_set;
  assign step_en = (state_q == FS_RUN) || start;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    trig_d  = trig_q;
    bpp_d   = bpp_q;
    lop_d   = lop_q;
    case (state_q)
      FS_IDLE: begin
        if (start) begin
          state_d = FS_RUN;
          addr_d  = '0;
          trig_d  = 1'b1;
          bpp_d   = bp_pat_in;
          lop_d   = lo_pat_in;
        end
      end
      FS_RUN: begin
        if (!blk_mode || addr_q == LAST) begin
          state_d = FS_IDLE;
          addr_d  = '0;
          trig_d  = 1'b0;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      default: begin
        state_d = FS_IDLE;
        trig_d  = 1'b0;
      end
    endcase
  end

  // State registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      trig_q  <= 1'b0;
      bpp_q   <= '0;
      lop_q   <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      trig_q  <= trig_d;
      bpp_q   <= bpp_d;
      lop_q   <= lop_d;
    end
  end

  assign busy       = (state_q == FS_RUN);
  assign trig_bit   = trig_q;
  assign fill_addr  = addr_q;
  assign bp_fill_we = busy && blk_mode && ({1'b0, addr_q} < BP_LIM);
  assign lo_fill_we = busy && blk_mode && ({1'b0, addr_q} < LO_LIM);
  assign bp_pat     = bpp_q;
  assign lo_pat     = lop_q;
endmodule

// File: rtl/cmfill_top.sv
module cmfill_top
  import cmfill_pkg::*;
#(
  parameter int unsigned BP_DEPTH  = 2048,
  parameter int unsigned LO_DEPTH  = 512,
  parameter int unsigned FRAME_CYC = 2048
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        blk_mode,
  input  logic                        trig_set,
  input  logic [2:0]                  bp_pat_in,
  input  logic [3:0]                  lo_pat_in,
  output logic                        trig_bit,
  output logic                        busy,
  input  logic                        cpu_bp_we,
  input  logic [$clog2(BP_DEPTH)-1:0] cpu_bp_addr,
  input  logic [15:0]                 cpu_bp_wdata,
  input  logic [$clog2(BP_DEPTH)-1:0] bp_rd_addr,
  output logic [15:0]                 bp_rd_data,
  input  logic                        cpu_lo_we,
  input  logic [$clog2(LO_DEPTH)-1:0] cpu_lo_addr,
  input  logic [15:0]                 cpu_lo_wdata,
  input  logic [$clog2(LO_DEPTH)-1:0] lo_rd_addr,
  output logic [15:0]                 lo_rd_data,
  input  logic                        cpu_hi_we,
  input  logic [$clog2(LO_DEPTH)-1:0] cpu_hi_addr,
  input  logic [15:0]                 cpu_hi_wdata,
  input  logic [$clog2(LO_DEPTH)-1:0] hi_rd_addr,
  output logic [15:0]                 hi_rd_data
);
  localparam int unsigned NMAX  = (BP_DEPTH > LO_DEPTH) ? BP_DEPTH : LO_DEPTH;
  localparam int unsigned AW    = $clog2(NMAX);
  localparam int unsigned BP_AW = $clog2(BP_DEPTH);
  localparam int unsigned LO_AW = $clog2(LO_DEPTH);

  // Asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic [AW-1:0]       fill_addr;
  logic                bp_fill_we, lo_fill_we;
  logic [BP_PAT_W-1:0] bp_pat;
  logic [LO_PAT_W-1:0] lo_pat;
  cm_word_t            bp_word, lo_word;

  cmfill_seq #(
    .BP_DEPTH (BP_DEPTH),
    .LO_DEPTH (LO_DEPTH),
    .NMAX     (NMAX),
    .AW       (AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_ns),
    .blk_mode   (blk_mode),
    .trig_set   (trig_set),
    .bp_pat_in  (bp_pat_in),
    .lo_pat_in  (lo_pat_in),
    .busy       (busy),
    .trig_bit   (trig_bit),
    .fill_addr  (fill_addr),
    .bp_fill_we (bp_fill_we),
    .lo_fill_we (lo_fill_we),
    .bp_pat     (bp_pat),
    .lo_pat     (lo_pat)
  );

  cmfill_field #(.W(CM_W), .FW(BP_PAT_W), .LSB(BP_FLD_LSB)) u_bp_fld (
    .pat  (bp_pat),
    .word (bp_word)
  );

  cmfill_field #(.W(CM_W), .FW(LO_PAT_W), .LSB(LO_FLD_LSB)) u_lo_fld (
    .pat  (lo_pat),
    .word (lo_word)
  );

  // Processor writes to the filled memories are dropped while busy
  logic bp_cpu_en, lo_cpu_en;
  assign bp_cpu_en = cpu_bp_we && !busy;
  assign lo_cpu_en = cpu_lo_we && !busy;

  cmfill_mem #(.DEPTH(BP_DEPTH), .W(CM_W), .AW(BP_AW)) u_bp_mem (
    .clk       (clk),
    .fill_we   (bp_fill_we),
    .fill_addr (fill_addr[BP_AW-1:0]),
    .fill_data (bp_word),
    .cpu_we    (bp_cpu_en),
    .cpu_addr  (cpu_bp_addr),
    .cpu_data  (cpu_bp_wdata),
    .rd_addr   (bp_rd_addr),
    .rd_data   (bp_rd_data)
  );

  cmfill_mem #(.DEPTH(LO_DEPTH), .W(CM_W), .AW(LO_AW)) u_lo_mem (
    .clk       (clk),
    .fill_we   (lo_fill_we),
    .fill_addr (fill_addr[LO_AW-1:0]),
    .fill_data (lo_word),
    .cpu_we    (lo_cpu_en),
    .cpu_addr  (cpu_lo_addr),
    .cpu_data  (cpu_lo_wdata),
    .rd_addr   (lo_rd_addr),
    .rd_data   (lo_rd_data)
  );

  // Upper local half: reachable by the processor only
  cmfill_mem #(.DEPTH(LO_DEPTH), .W(CM_W), .AW(LO_AW)) u_hi_mem (
    .clk       (clk),
    .fill_we   (1'b0),
    .fill_addr ('0),
    .fill_data ('0),
    .cpu_we    (cpu_hi_we),
    .cpu_addr  (cpu_hi_addr),
    .cpu_data  (cpu_hi_wdata),
    .rd_addr   (hi_rd_addr),
    .rd_data   (hi_rd_data)
  );
endmodule

// File: rtl/cmfill_chk.sv
module cmfill_chk #(
  parameter int unsigned BP_DEPTH  = 2048,
  parameter int unsigned LO_DEPTH  = 512,
  parameter int unsigned FRAME_CYC = 2048,
  parameter int unsigned NMAX      = (BP_DEPTH > LO_DEPTH) ? BP_DEPTH : LO_DEPTH,
  parameter int unsigned AW        = $clog2(NMAX)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_mode,
  input logic          trig_set,
  input logic          busy,
  input logic          trig_bit,
  input logic [AW-1:0] fill_addr
);
  int unsigned run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  // R2
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(blk_mode) && $past(trig_set)));

  // R6
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> trig_bit);

  // R6
  trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !trig_bit);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_mode) |=> !busy);

  // R11
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (fill_addr == $past(fill_addr) + 1'b1));

  // R7
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < 2 * FRAME_CYC));
endmodule

bind cmfill_top cmfill_chk #(
  .BP_DEPTH  (BP_DEPTH),
  .LO_DEPTH  (LO_DEPTH),
  .FRAME_CYC (FRAME_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .blk_mode  (blk_mode),
  .trig_set  (trig_set),
  .busy      (busy),
  .trig_bit  (trig_bit),
  .fill_addr (fill_addr)
);

// File: tb/cmfill_top_test.sv
module cmfill_top_test;
  localparam int BP_DEPTH  = 2048;
  localparam int LO_DEPTH  = 512;
  localparam int FRAME_CYC = 2048;
  localparam int NMAX      = (BP_DEPTH > LO_DEPTH) ? BP_DEPTH : LO_DEPTH;
  localparam int BP_AW     = $clog2(BP_DEPTH);
  localparam int LO_AW     = $clog2(LO_DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, blk_mode, trig_set, trig_bit, busy;
  logic [2:0]       bp_pat_in;
  logic [3:0]       lo_pat_in;
  logic             cpu_bp_we, cpu_lo_we, cpu_hi_we;
  logic [BP_AW-1:0] cpu_bp_addr, bp_rd_addr;
  logic [LO_AW-1:0] cpu_lo_addr, lo_rd_addr, cpu_hi_addr, hi_rd_addr;
  logic [15:0]      cpu_bp_wdata, cpu_lo_wdata, cpu_hi_wdata;
  logic [15:0]      bp_rd_data, lo_rd_data, hi_rd_data;

  cmfill_top #(.BP_DEPTH(BP_DEPTH), .LO_DEPTH(LO_DEPTH), .FRAME_CYC(FRAME_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .trig_set(trig_set),
    .bp_pat_in(bp_pat_in), .lo_pat_in(lo_pat_in), .trig_bit(trig_bit), .busy(busy),
    .cpu_bp_we(cpu_bp_we), .cpu_bp_addr(cpu_bp_addr), .cpu_bp_wdata(cpu_bp_wdata),
    .bp_rd_addr(bp_rd_addr), .bp_rd_data(bp_rd_data),
    .cpu_lo_we(cpu_lo_we), .cpu_lo_addr(cpu_lo_addr), .cpu_lo_wdata(cpu_lo_wdata),
    .lo_rd_addr(lo_rd_addr), .lo_rd_data(lo_rd_data),
    .cpu_hi_we(cpu_hi_we), .cpu_hi_addr(cpu_hi_addr), .cpu_hi_wdata(cpu_hi_wdata),
    .hi_rd_addr(hi_rd_addr), .hi_rd_data(hi_rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard: sel 0 = backplane, 1 = lower local, 2 = upper local
  typedef struct {
    int          sel;
    int          addr;
    logic [15:0] exp;
    string       req;
  } sb_item_t;
  sb_item_t sbq[$];
  bit mon_active = 1'b0;

  task automatic expect_word(input int sel, input int addr, input logic [15:0] exp,
                             input string req);
    sb_item_t it;
    it.sel = sel; it.addr = addr; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() > 0 || mon_active) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: one read-back per cycle, away from the rising edge
  initial begin
    bp_rd_addr = '0; lo_rd_addr = '0; hi_rd_addr = '0;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        sb_item_t it;
        logic [15:0] act;
        mon_active = 1'b1;
        it = sbq.pop_front();
        bp_rd_addr = BP_AW'(it.addr);
        lo_rd_addr = LO_AW'(it.addr);
        hi_rd_addr = LO_AW'(it.addr);
        #1;
        case (it.sel)
          0:       act = bp_rd_data;
          1:       act = lo_rd_data;
          default: act = hi_rd_data;
        endcase
        check($sformatf("%s sel%0d addr%0d", it.req, it.sel, it.addr), int'(act), int'(it.exp));
        mon_active = 1'b0;
      end
    end
  end

  function automatic logic [15:0] bp_word(input logic [2:0] p);
    return {2'b00, p, 11'b0};
  endfunction
  function automatic logic [15:0] lo_word(input logic [3:0] p);
    return {p, 12'b0};
  endfunction

  // Driver: one fill, optionally with colliding stimulus or an abort
  task automatic run_fill(input logic [2:0] bp, input logic [3:0] lo, input int abort_at,
                          input bit extras, output int len);
    @(negedge clk);
    bp_pat_in = bp; lo_pat_in = lo; blk_mode = 1'b1; trig_set = 1'b1;
    if (extras) begin
      cpu_bp_we = 1'b1; cpu_bp_addr = BP_AW'(3); cpu_bp_wdata = 16'hFFFF;
    end
    @(negedge clk);
    trig_set = 1'b0; cpu_bp_we = 1'b0;
    check("R2 busy after trigger", int'(busy), 1);
    check("R6 trig_bit while busy", int'(trig_bit), 1);
    len = 0;
    while (busy && len <= 3 * NMAX) begin
      len++;
      cpu_bp_we = 1'b0; cpu_lo_we = 1'b0; trig_set = 1'b0;
      if (extras) begin
        if (len == 10 || len == NMAX) begin
          cpu_bp_we = 1'b1; cpu_lo_we = 1'b1;
          cpu_bp_addr  = BP_AW'((len == 10) ? 5 : 0);
          cpu_lo_addr  = LO_AW'((len == 10) ? 5 : 0);
          cpu_bp_wdata = 16'hFFFF; cpu_lo_wdata = 16'hFFFF;
        end
        if (len == 20) trig_set = 1'b1;
        if (len == 30) begin
          bp_pat_in = ~bp; lo_pat_in = ~lo;
        end
      end
      if (abort_at != 0 && len == abort_at) blk_mode = 1'b0;
      @(negedge clk);
    end
    cpu_bp_we = 1'b0; cpu_lo_we = 1'b0; trig_set = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    rst_n = 1'b0; blk_mode = 1'b0; trig_set = 1'b0;
    bp_pat_in = '0; lo_pat_in = '0;
    cpu_bp_we = 1'b0; cpu_lo_we = 1'b0; cpu_hi_we = 1'b0;
    cpu_bp_addr = '0; cpu_lo_addr = '0; cpu_hi_addr = '0;
    cpu_bp_wdata = '0; cpu_lo_wdata = '0; cpu_hi_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    check("R1 busy after reset", int'(busy), 0);
    check("R1 trig_bit after reset", int'(trig_bit), 0);

    // R8 idle writes accepted; R5 upper half seeded
    cpu_bp_we = 1'b1; cpu_bp_addr = BP_AW'(7); cpu_bp_wdata = 16'h1234;
    cpu_lo_we = 1'b1; cpu_lo_addr = LO_AW'(7); cpu_lo_wdata = 16'h4321;
    cpu_hi_we = 1'b1; cpu_hi_addr = LO_AW'(17); cpu_hi_wdata = 16'hBEEF;
    @(negedge clk);
    cpu_bp_we = 1'b0; cpu_lo_we = 1'b0; cpu_hi_we = 1'b0;
    expect_word(0, 7, 16'h1234, "R8 idle write");
    expect_word(1, 7, 16'h4321, "R8 idle write");
    drain();

    // R2 trigger without mode
    trig_set = 1'b1; blk_mode = 1'b0;
    @(negedge clk);
    trig_set = 1'b0;
    check("R2 no start without mode busy", int'(busy), 0);
    check("R2 no start without mode trig", int'(trig_bit), 0);
    expect_word(0, 7, 16'h1234, "R2 memory untouched");
    drain();

    // Full fill with collisions (R3 R4 R5 R6 R7 R8 R10 R11)
    run_fill(3'b101, 4'b1001, 0, 1'b1, len);
    check("R6 R11 busy length", len, NMAX);
    check("R7 within two frames", int'(len <= 2 * FRAME_CYC), 1);
    check("R6 trig_bit cleared", int'(trig_bit), 0);
    for (int a = 0; a < BP_DEPTH; a++) expect_word(0, a, bp_word(3'b101), "R3 R10 R8 bp word");
    for (int a = 0; a < LO_DEPTH; a++) expect_word(1, a, lo_word(4'b1001), "R4 R10 R8 lo word");
    expect_word(2, 17, 16'hBEEF, "R5 upper half kept");
    drain();

    // R9 abort after 100 busy cycles: addresses 0..98 new, 99 on old
    run_fill(3'b010, 4'b0110, 100, 1'b0, len);
    check("R9 abort length", len, 100);
    check("R9 trig_bit cleared", int'(trig_bit), 0);
    expect_word(0, 98, bp_word(3'b010), "R9 reached word");
    expect_word(0, 99, bp_word(3'b101), "R9 unreached word");
    expect_word(1, 98, lo_word(4'b0110), "R9 reached word");
    expect_word(1, 99, lo_word(4'b1001), "R9 unreached word");
    drain();

    // Full pattern, boundaries (R3 R4)
    run_fill(3'b111, 4'b1111, 0, 1'b0, len);
    check("R6 busy length second run", len, NMAX);
    expect_word(0, 0, bp_word(3'b111), "R3 first");
    expect_word(0, BP_DEPTH - 1, bp_word(3'b111), "R3 last");
    expect_word(0, LO_DEPTH, bp_word(3'b111), "R3 past local depth");
    expect_word(1, 0, lo_word(4'b1111), "R4 first");
    expect_word(1, LO_DEPTH - 1, lo_word(4'b1111), "R4 last");
    expect_word(2, 17, 16'hBEEF, "R5 upper half kept again");
    drain();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule